// File: doc/BRIEF.md
# Serial RGB LCD Timing Generator

This block drives a small RGB panel that takes one colour component per port-clock tick over an 8-bit bus, so a pixel occupies three ticks. It produces an active-low horizontal sync and an active-low vertical sync, each from its own free-running period counter measured in port-clock ticks. The vertical counter is launched one tick ahead of the horizontal counter whenever the block is enabled, so every frame's vertical pulse begins exactly one tick before a horizontal pulse.

On every line except the leading blanking line(s) of a frame, a data-enable window opens a programmed number of ticks after the start of the horizontal pulse and stays open for a fixed number of ticks (by default 204 and 960: 320 pixels of three ticks each inside a 1224-tick line; a frame is 241 lines with a 3-line vertical pulse). Inside the window the block pulls 16-bit words over a ready/valid input and sends each one out as two bytes, low byte first. Outside the window the byte output is zero.

A synchronous enable clears both counters; while it is low the syncs rest high and nothing is requested.

Top module: `lcd_sync_gen`

## Requirements
- R1: While rst_n is low or en is low, hsync_n and vsync_n are 1, de is 0, word_ready is 0 and pix_byte is 0.
- R2: Counting enabled ticks from the one where en is first seen high as tick 0, hsync_n is 0 on ticks t>=1 with (t-1) mod H_TOTAL < H_SYNC, and 1 on all other ticks.
- R3: vsync_n is 0 on ticks t with t mod (H_TOTAL*V_LINES) < V_SYNC_LINES*H_TOTAL, and 1 otherwise, so its falling edge comes one tick before a falling edge of hsync_n.
- R4: With line index L = floor((t-1)/H_TOTAL) mod V_LINES and position p = (t-1) mod H_TOTAL, de is 1 exactly when t>=1, L >= V_BLANK and H_DELAY <= p < H_DELAY+H_ACTIVE.
- R5: A word accepted on a tick (word_ready and word_valid both 1) puts word_data[7:0] on pix_byte in that same tick and word_data[15:8] on pix_byte in the next tick, provided de is still 1.
- R6: word_ready is 1 only while de is 1, and only on ticks that do not carry the high byte of a previously accepted word.
- R7: pix_byte is 0 whenever de is 0, and also on a tick where word_ready is 1 but word_valid is 0; such a tick leaves the next tick asking for a word again.
- R8: Dropping en for one or more ticks and raising it again restarts the sync and window sequence from tick 0 exactly as after reset, discarding any pending high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, one tick per transferred byte |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable; low clears both counters |
| word_data | input | 16 | Packed pixel word, low byte sent first |
| word_valid | input | 1 | word_data holds a word |
| word_ready | output | 1 | Block takes word_data on this tick |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data window open |
| pix_byte | output | 8 | Serial colour byte, zero outside the window |

## Verification
A counter that slips by a single tick shows at once as a sync or de edge one tick off the expected position, and because the reference is evaluated every tick the mismatch is caught on the first line. A line counter that is wrong shows up at the next line boundary as a window on the blanking line or a missing window on an active line. A packer phase that is out of step puts a high byte where a low byte belongs, or raises word_ready on a high-byte tick, within two ticks of the first accepted word; stall ticks with word_valid low push the phase around so a stuck phase is exposed.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] pix_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/lcd_vtimer.sv
module lcd_vtimer #(
  parameter int H_TOTAL      = 1224,
  parameter int V_LINES      = 241,
  parameter int V_SYNC_LINES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic run,
  output logic vsync_n
);
  localparam int V_TOTAL = H_TOTAL * V_LINES;
  localparam int V_SYNC  = V_SYNC_LINES * H_TOTAL;
  localparam int VW      = $clog2(V_TOTAL + 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_SW   = VW'(V_SYNC);

  logic [VW-1:0] cnt_q, cnt_d;
  logic          run_d;

  always_comb begin
    run_d = en;
    cnt_d = cnt_q;
    if (!en)
      cnt_d = '0;
    else if (run)
      cnt_d = (cnt_q == V_LAST) ? '0 : cnt_q + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt_q <= '0;
    end else begin
      run   <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign vsync_n = !(run && (cnt_q < V_SW));
endmodule

// File: rtl/lcd_htimer.sv
module lcd_htimer #(
  parameter int H_TOTAL  = 1224,
  parameter int H_SYNC   = 90,
  parameter int H_DELAY  = 204,
  parameter int H_ACTIVE = 960,
  parameter int V_LINES  = 241,
  parameter int V_BLANK  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  output logic hsync_n,
  output logic win
);
  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int LW = $clog2(V_LINES + 1);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_SW    = HW'(H_SYNC);
  localparam logic [HW-1:0] W_OPEN  = HW'(H_DELAY);
  localparam logic [HW-1:0] W_CLOSE = HW'(H_DELAY + H_ACTIVE);
  localparam logic [LW-1:0] L_LAST  = LW'(V_LINES - 1);
  localparam logic [LW-1:0] L_FIRST = LW'(V_BLANK);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [LW-1:0] line_q, line_d;
  logic          run_q, run_d;
  logic          eol;

  assign eol = run_q && (hcnt_q == H_LAST);

  always_comb begin
    run_d  = en && start;
    hcnt_d = hcnt_q;
    line_d = line_q;
    if (!en) begin
      hcnt_d = '0;
      line_d = '0;
    end else if (run_q) begin
      hcnt_d = eol ? '0 : hcnt_q + HW'(1);
      if (eol)
        line_d = (line_q == L_LAST) ? '0 : line_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hcnt_q <= '0;
      line_q <= '0;
    end else begin
      run_q  <= run_d;
      hcnt_q <= hcnt_d;
      line_q <= line_d;
    end
  end

  assign hsync_n = !(run_q && (hcnt_q < H_SW));
  assign win     = run_q && (line_q >= L_FIRST) &&
                   (hcnt_q >= W_OPEN) && (hcnt_q < W_CLOSE);
endmodule

// File: rtl/lcd_packer.sv
module lcd_packer
  import lcd_tim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  win,
  input  word_t word_data,
  input  logic  word_valid,
  output logic  word_ready,
  output pix_t  pix_byte
);
  logic phase_q, phase_d;
  pix_t hold_q;
  logic take;

  assign word_ready = win && !phase_q;
  assign take       = word_ready && word_valid;

  always_comb begin
    phase_d = 1'b0;
    if (win && !phase_q && word_valid)
      phase_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= 1'b0;
    else
      phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (take)
      hold_q <= word_data[WORD_W-1:BYTE_W];
  end

  always_comb begin
    pix_byte = '0;
    if (win) begin
      if (phase_q)
        pix_byte = hold_q;
      else if (word_valid)
        pix_byte = word_data[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int H_TOTAL      = 1224,
  parameter int H_SYNC       = 90,
  parameter int H_DELAY      = 204,
  parameter int H_ACTIVE     = 960,
  parameter int V_LINES      = 241,
  parameter int V_BLANK      = 1,
  parameter int V_SYNC_LINES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [15:0] word_data,
  input  logic        word_valid,
  output logic        word_ready,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        de,
  output logic [7:0]  pix_byte
);
  logic rst_i_n;
  logic v_run;
  logic win;

  lcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  lcd_vtimer #(
    .H_TOTAL      (H_TOTAL),
    .V_LINES      (V_LINES),
    .V_SYNC_LINES (V_SYNC_LINES)
  ) u_vt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .run     (v_run),
    .vsync_n (vsync_n)
  );

  lcd_htimer #(
    .H_TOTAL  (H_TOTAL),
    .H_SYNC   (H_SYNC),
    .H_DELAY  (H_DELAY),
    .H_ACTIVE (H_ACTIVE),
    .V_LINES  (V_LINES),
    .V_BLANK  (V_BLANK)
  ) u_ht (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .start   (v_run),
    .hsync_n (hsync_n),
    .win     (win)
  );

  lcd_packer u_pk (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .win        (win),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .pix_byte   (pix_byte)
  );

  assign de = win;
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int H_SYNC = 90
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       word_valid,
  input logic       word_ready,
  input logic       hsync_n,
  input logic       vsync_n,
  input logic       de,
  input logic [7:0] pix_byte
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lo_cnt <= '0;
    else if (!hsync_n)
      lo_cnt <= lo_cnt + 16'd1;
    else
      lo_cnt <= '0;
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hsync_n && vsync_n && !de && !word_ready));

  p_hs_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hsync_n) && $past(en) && en) |-> (lo_cnt == 16'(H_SYNC)));

  p_vs_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) && en) |=> $fell(hsync_n));

  p_hi_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid) |=> !word_ready);

  p_ready_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> de);

  p_zero_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix_byte == 8'h00));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.H_SYNC(H_SYNC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .de         (de),
  .pix_byte   (pix_byte)
);

// File: tb/test_lcd_sync_gen.sv
`timescale 1ns/1ps
module test_lcd_sync_gen;
  localparam int HT = 40, HS = 5, HD = 8, HA = 24, VL = 6, VB = 1, VSL = 2;
  localparam int VT = HT * VL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready, hsync_n, vsync_n, de;
  logic [7:0]  pix_byte;

  int total = 0, bad = 0;
  int age = 0;
  int ph = 0;
  int hold = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit second_run = 1'b0;

  always #2.5 clk = ~clk;

  lcd_sync_gen #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_DELAY(HD), .H_ACTIVE(HA),
    .V_LINES(VL), .V_BLANK(VB), .V_SYNC_LINES(VSL)
  ) i_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .de(de), .pix_byte(pix_byte)
  );

  function automatic bit exp_win(int a);
    int p, l;
    if (a < 2) return 1'b0;
    p = (a - 2) % HT;
    l = ((a - 2) / HT) % VL;
    return (l >= VB) && (p >= HD) && (p < HD + HA);
  endfunction

  function automatic bit exp_hs(int a);
    if (a < 2) return 1'b1;
    return !(((a - 2) % HT) < HS);
  endfunction

  function automatic bit exp_vs(int a);
    if (a < 1) return 1'b1;
    return !(((a - 1) % VT) < VSL * HT);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // reference model advance
  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !en) begin
      age = 0;
      ph = 0;
    end else begin
      if (!exp_win(age)) ph = 0;
      else if (ph == 1) ph = 0;
      else if (word_valid) begin
        hold = int'(word_data[15:8]);
        ph = 1;
      end
      age++;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    bit w, rdy;
    int eb;
    w = exp_win(age);
    rdy = w && (ph == 0);
    if (!rst_n || age == 0) begin
      check("R1 hsync_n", int'(hsync_n), 1);
      check("R1 vsync_n", int'(vsync_n), 1);
      check("R1 de", int'(de), 0);
      check("R1 word_ready", int'(word_ready), 0);
      check("R1 pix_byte", int'(pix_byte), 0);
    end else begin
      check(second_run ? "R8 hsync_n" : "R2 hsync_n", int'(hsync_n), int'(exp_hs(age)));
      check("R3 vsync_n", int'(vsync_n), int'(exp_vs(age)));
      check(second_run ? "R8 de" : "R4 de", int'(de), int'(w));
      check("R6 word_ready", int'(word_ready), int'(rdy));
      if (!w) eb = 0;
      else if (ph == 1) eb = hold;
      else if (word_valid) eb = int'(word_data[7:0]);
      else eb = 0;
      check((w && (ph == 1 || word_valid)) ? "R5 pix_byte" : "R7 pix_byte",
            int'(pix_byte), eb);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      word_data  = 16'(cyc * 37 + 11);
      word_valid = !(stall_mode && ((cyc % 5) == 2));
    end
  endtask

  initial begin
    fork
      begin
        step(5);
        rst_n = 1'b1;
        step(10);
        en = 1'b1;
        step(VT);
        stall_mode = 1'b1;
        step(2 * VT + 17);
        en = 1'b0;
        step(20);
        second_run = 1'b1;
        en = 1'b1;
        step(VT + 30);
        en = 1'b0;
        step(5);
      end
      begin
        #(50000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule